// File: doc/BRIEF.md
# Chip-Select Port Sizer

This block sits between a CPU-style bus master and one external memory region. It produces an active-low chip-select and two active-low byte-lane selects (upper and lower). It routes data between the master's 16-bit bus and a memory port that is either 8 or 16 bits wide, and it forms the address that the memory sees. The port width is not programmable. It is taken from a strap input at the end of reset. A board-level pull-up on that strap gives a 16-bit port by default, and holding the strap low during reset gives an 8-bit port.

The region is one window, set by the `BASE` and `MASK` parameters. Address bits of `BASE` outside `MASK` must be zero. A narrow memory is wired to the upper half of the data bus, and each narrow access moves one byte. A wide memory has its word address formed from bus address bit 1 upward. Separate lane selects let single-byte writes on the wide port touch only one byte. A misaligned word access to the wide port is refused and flagged. Every output is registered and follows its inputs by one clock.

Top module: `csz_port_sizer`

## Requirements
- R1: On every rising edge while `rst` is high, the port width is loaded from `strap_i`: 1 selects a 16-bit port and 0 selects an 8-bit port. The width loaded on the last edge of reset holds until the next reset, and later changes of `strap_i` have no effect.
- R2: One cycle after a cycle in which `bus_strobe_i` is high, `(bus_addr_i & MASK) == BASE`, and the access is not refused (R8), `cs_n_o` is 0. Otherwise `cs_n_o` is 1. `mem_rw_o` is the value of `bus_rw_i` one cycle earlier (1 = read, 0 = write).
- R3: On a 16-bit port, an accepted access drives the lane selects as follows. A word access drives `hi_n_o` and `lo_n_o` both to 0. A byte access at an even address drives only `hi_n_o` to 0. A byte access at an odd address drives only `lo_n_o` to 0. Size code 2'b01 means byte, and every other code means word.
- R4: On an 8-bit port, any accepted access drives `hi_n_o` to 0 and keeps `lo_n_o` at 1, whatever the size code.
- R5: On a 16-bit port, `mem_addr_o` is `bus_addr_i` shifted right by one, so bus bit 0 is ignored and bus bit 1 becomes memory bit 0. On an 8-bit port, `mem_addr_o` equals `bus_addr_i`.
- R6: On a 16-bit write, `mem_wdata_o` equals `bus_wdata_i`. On an 8-bit write, one byte is taken from `bus_wdata_i[15:8]` when address bit 0 is 0, or from `bus_wdata_i[7:0]` when it is 1, and that byte is driven on both halves of `mem_wdata_o`. During reads, `mem_wdata_o` is zero.
- R7: On a 16-bit port, `bus_rdata_o` is `mem_rdata_i` from the previous cycle. On an 8-bit port, both halves of `bus_rdata_o` carry the previous cycle's `mem_rdata_i[15:8]`.
- R8: On a 16-bit port, a word access to an odd address inside the region is refused, and all three selects stay at 1. `err_o` is 1 for exactly one cycle, following the first cycle of that strobe. It stays 0 while the strobe is held.
- R9: On any edge with `rst` high, `cs_n_o`, `hi_n_o`, `lo_n_o` and `mem_rw_o` become 1, and `err_o`, `mem_addr_o`, `mem_wdata_o` and `bus_rdata_o` become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_i | input | 1 | Width strap sampled during reset (1 = 16-bit) |
| bus_addr_i | input | AW | Byte address from the master |
| bus_size_i | input | 2 | Size code, 2'b01 byte, others word |
| bus_rw_i | input | 1 | 1 = read, 0 = write |
| bus_strobe_i | input | 1 | Transfer strobe, active high |
| bus_wdata_i | input | 16 | Write data from the master |
| bus_rdata_o | output | 16 | Read data to the master |
| mem_rdata_i | input | 16 | Read data from the memory |
| mem_addr_o | output | AW | Memory-side address |
| mem_wdata_o | output | 16 | Write data to the memory |
| mem_rw_o | output | 1 | Registered read/write to the memory |
| cs_n_o | output | 1 | Region chip-select, active low |
| hi_n_o | output | 1 | Upper byte-lane select, active low |
| lo_n_o | output | 1 | Lower byte-lane select, active low |
| err_o | output | 1 | One-cycle pulse on a refused access |

## Verification
The bench covers both strap values. After each release it toggles the strap, so a width register that kept sampling would swap the address shift and lane rules in the middle of the run. It drives byte accesses at even and odd addresses and word accesses. A decoder that reversed the lane parity, or that let a narrow port use the lower lane, shows up as wrong selects or as echoed write data that does not match. It holds a misaligned word strobe for two cycles. A flag that is level-driven instead of pulsed, or a refusal that still asserts a select, is caught on the second cycle. Addresses just outside the window and idle cycles with a matching address confirm that the chip-select depends on both the mask compare and the strobe.

// File: rtl/csz_pkg.sv
package csz_pkg;
  typedef logic [1:0] size_code_t;
  localparam size_code_t SZ_BYTE = 2'b01;

  function automatic logic is_word(input size_code_t s);
    return s != SZ_BYTE;
  endfunction
endpackage

// File: rtl/csz_width_latch.sv
module csz_width_latch (
  input  logic clk,
  input  logic rst,
  input  logic strap_i,
  output logic port16_o
);
  logic port16_q;

  always_ff @(posedge clk) begin
    if (rst) port16_q <= strap_i;
  end

  assign port16_o = port16_q;

  // R1: width never moves outside reset
  a_r1_width_held: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(port16_q));
endmodule

// File: rtl/csz_decode.sv
module csz_decode
  import csz_pkg::*;
#(
  parameter int AW = 20,
  parameter logic [AW-1:0] BASE = 20'h40000,
  parameter logic [AW-1:0] MASK = 20'hF0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          port16_i,
  input  logic [AW-1:0] addr_i,
  input  size_code_t    size_i,
  input  logic          strobe_i,
  output logic          cs_n_o,
  output logic          hi_n_o,
  output logic          lo_n_o,
  output logic          err_o
);
  logic hit, word, odd, reject, grant, want_hi, want_lo;
  logic strobe_q;

  always_comb begin
    hit     = strobe_i && ((addr_i & MASK) == BASE);
    word    = is_word(size_i);
    odd     = addr_i[0];
    reject  = port16_i && word && odd;
    grant   = hit && !reject;
    want_hi = port16_i ? (word || !odd) : 1'b1;
    want_lo = port16_i ? (word || odd)  : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b0;
      cs_n_o   <= 1'b1;
      hi_n_o   <= 1'b1;
      lo_n_o   <= 1'b1;
      err_o    <= 1'b0;
    end else begin
      strobe_q <= strobe_i;
      cs_n_o   <= !grant;
      hi_n_o   <= !(grant && want_hi);
      lo_n_o   <= !(grant && want_lo);
      err_o    <= hit && reject && !strobe_q;
    end
  end

  // R3: a lane select never appears without the region select
  a_r3_lane_needs_cs: assert property (@(posedge clk) disable iff (rst)
    (!hi_n_o || !lo_n_o) |-> !cs_n_o);
  // R3: both lanes only for a word access
  a_r3_both_word: assert property (@(posedge clk) disable iff (rst)
    (!hi_n_o && !lo_n_o) |-> is_word($past(size_i)));
  // R4: narrow port keeps the lower lane idle
  a_r4_narrow_upper: assert property (@(posedge clk) disable iff (rst)
    !port16_i |-> lo_n_o);
  // R8: refused access selects nothing
  a_r8_err_alone: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (cs_n_o && hi_n_o && lo_n_o));
  // R8: flag lasts a single cycle
  a_r8_err_pulse: assert property (@(posedge clk) disable iff (rst)
    err_o |=> !err_o);
endmodule

// File: rtl/csz_steer.sv
module csz_steer #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          port16_i,
  input  logic [AW-1:0] addr_i,
  input  logic          rw_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_rw_o,
  output logic [DW-1:0] rdata_o
);
  localparam int BW    = DW / 2;
  localparam int LANES = DW / BW;

  logic [BW-1:0] wr_byte;
  logic [DW-1:0] wr_echo, rd_echo, wr_next, rd_next;
  logic [AW-1:0] addr_next;

  assign wr_byte = addr_i[0] ? wdata_i[BW-1:0] : wdata_i[DW-1:BW];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wr_echo[g*BW +: BW] = wr_byte;
    assign rd_echo[g*BW +: BW] = mem_rdata_i[DW-1:BW];
  end

  always_comb begin
    addr_next = port16_i ? {1'b0, addr_i[AW-1:1]} : addr_i;
    wr_next   = rw_i ? '0 : (port16_i ? wdata_i : wr_echo);
    rd_next   = port16_i ? mem_rdata_i : rd_echo;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      mem_rw_o    <= 1'b1;
      rdata_o     <= '0;
    end else begin
      mem_addr_o  <= addr_next;
      mem_wdata_o <= wr_next;
      mem_rw_o    <= rw_i;
      rdata_o     <= rd_next;
    end
  end

  // R6: narrow port writes the same byte on both halves
  a_r6_echo: assert property (@(posedge clk) disable iff (rst)
    !port16_i |-> (mem_wdata_o[DW-1:BW] == mem_wdata_o[BW-1:0]));
  // R6: reads leave the write bus quiet
  a_r6_read_quiet: assert property (@(posedge clk) disable iff (rst)
    mem_rw_o |-> (mem_wdata_o == '0));
  // R7: narrow read data duplicated
  a_r7_read_dup: assert property (@(posedge clk) disable iff (rst)
    !port16_i |-> (rdata_o[DW-1:BW] == rdata_o[BW-1:0]));
  // R5: wide port word address has a clear top bit
  a_r5_word_addr: assert property (@(posedge clk) disable iff (rst)
    port16_i |-> !mem_addr_o[AW-1]);
endmodule

// File: rtl/csz_port_sizer.sv
module csz_port_sizer
  import csz_pkg::*;
#(
  parameter int AW = 20,
  parameter logic [AW-1:0] BASE = 20'h40000,
  parameter logic [AW-1:0] MASK = 20'hF0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strap_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [1:0]    bus_size_i,
  input  logic          bus_rw_i,
  input  logic          bus_strobe_i,
  input  logic [15:0]   bus_wdata_i,
  output logic [15:0]   bus_rdata_o,
  input  logic [15:0]   mem_rdata_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [15:0]   mem_wdata_o,
  output logic          mem_rw_o,
  output logic          cs_n_o,
  output logic          hi_n_o,
  output logic          lo_n_o,
  output logic          err_o
);
  logic port16;

  csz_width_latch u_width (
    .clk(clk), .rst(rst), .strap_i(strap_i), .port16_o(port16)
  );

  csz_decode #(.AW(AW), .BASE(BASE), .MASK(MASK)) u_decode (
    .clk(clk), .rst(rst), .port16_i(port16), .addr_i(bus_addr_i),
    .size_i(size_code_t'(bus_size_i)), .strobe_i(bus_strobe_i),
    .cs_n_o(cs_n_o), .hi_n_o(hi_n_o), .lo_n_o(lo_n_o), .err_o(err_o)
  );

  csz_steer #(.AW(AW), .DW(16)) u_steer (
    .clk(clk), .rst(rst), .port16_i(port16), .addr_i(bus_addr_i),
    .rw_i(bus_rw_i), .wdata_i(bus_wdata_i), .mem_rdata_i(mem_rdata_i),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rw_o(mem_rw_o), .rdata_o(bus_rdata_o)
  );
endmodule

// File: tb/test_csz_port_sizer.sv
`timescale 1ns/1ps
module test_csz_port_sizer;
  localparam int AW = 20;
  localparam logic [AW-1:0] BASE = 20'h40000;
  localparam logic [AW-1:0] MASK = 20'hF0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strap = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [1:0] size = 2'b10;
  logic rw = 1'b1, stb = 1'b0;
  logic [15:0] wd = '0, rd = '0;
  logic [15:0] bus_rdata, mem_wdata;
  logic [AW-1:0] mem_addr;
  logic mem_rw, cs_n, hi_n, lo_n, err;

  int total = 0, bad = 0;
  bit w16 = 1'b1, prev_stb = 1'b0, finished = 1'b0;

  always #10 clk = ~clk;

  csz_port_sizer #(.AW(AW), .BASE(BASE), .MASK(MASK)) i_csz_port_sizer (
    .clk(clk), .rst(rst), .strap_i(strap), .bus_addr_i(addr),
    .bus_size_i(size), .bus_rw_i(rw), .bus_strobe_i(stb),
    .bus_wdata_i(wd), .bus_rdata_o(bus_rdata), .mem_rdata_i(rd),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rw_o(mem_rw),
    .cs_n_o(cs_n), .hi_n_o(hi_n), .lo_n_o(lo_n), .err_o(err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk);
    rst = 1'b1; strap = s; stb = 1'b0; rw = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 cs_n", cs_n, 1); chk("R9 hi_n", hi_n, 1); chk("R9 lo_n", lo_n, 1);
    chk("R9 err", err, 0); chk("R9 mem_addr", mem_addr, 0);
    chk("R9 mem_wdata", mem_wdata, 0); chk("R9 rdata", bus_rdata, 0);
    chk("R9 mem_rw", mem_rw, 1);
    rst = 1'b0; w16 = s; prev_stb = 1'b0;
    @(posedge clk);
    @(negedge clk);
    strap = ~s;  // R1: must be ignored from here on
  endtask

  // inputs change at a negedge; outputs checked at the following negedge
  task automatic step(input logic [AW-1:0] a, input logic [1:0] sz, input logic r,
                      input logic s, input logic [15:0] w, input logic [15:0] m);
    bit hit, word, odd, rej, gr;
    logic [7:0] bt;
    logic [15:0] e_wd, e_rd;
    logic [AW-1:0] e_addr;
    logic e_cs, e_hi, e_lo, e_err;
    addr = a; size = sz; rw = r; stb = s; wd = w; rd = m;
    hit  = s && ((a & MASK) == BASE);
    word = (sz != 2'b01);
    odd  = a[0];
    rej  = w16 && word && odd;
    gr   = hit && !rej;
    e_cs = !gr;
    e_hi = !(gr && (w16 ? (word || !odd) : 1'b1));
    e_lo = !(gr && w16 && (word || odd));
    e_err = hit && rej && !prev_stb;
    e_addr = w16 ? (a >> 1) : a;
    bt = odd ? w[7:0] : w[15:8];
    e_wd = r ? 16'h0 : (w16 ? w : {bt, bt});
    e_rd = w16 ? m : {m[15:8], m[15:8]};
    @(posedge clk);
    prev_stb = s;
    @(negedge clk);
    chk("R2 cs_n", cs_n, e_cs);
    chk("R2 mem_rw", mem_rw, r);
    chk(w16 ? "R3 hi_n" : "R4 hi_n", hi_n, e_hi);
    chk(w16 ? "R3 lo_n" : "R4 lo_n", lo_n, e_lo);
    chk("R8 err", err, e_err);
    chk("R5 R1 mem_addr", mem_addr, e_addr);
    chk("R6 mem_wdata", mem_wdata, e_wd);
    chk("R7 rdata", bus_rdata, e_rd);
  endtask

  task automatic mixed_run(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      int v;
      v = (i * 37 + seed * 11) & 32'hFFFF;
      step({((i % 5) == 0) ? 4'h5 : 4'h4, v[15:0]} ^ AW'(i & 1),
           ((i % 3) == 0) ? 2'b01 : 2'(i % 4), (i % 2) == 1, (i % 7) != 6,
           16'(v * 3 + 16'h1357), 16'(v ^ 16'hA55A));
    end
  endtask

  initial begin
    // 16-bit port
    do_reset(1'b1);
    step(20'h40010, 2'b10, 1'b1, 1'b1, 16'h0000, 16'hBEEF);  // R3 word read
    step(20'h40012, 2'b10, 1'b0, 1'b1, 16'h1234, 16'h0000);  // R6 word write
    step(20'h40014, 2'b01, 1'b0, 1'b1, 16'hAB00, 16'h0000);  // R3 byte even
    step(20'h40015, 2'b01, 1'b0, 1'b1, 16'h00CD, 16'h0000);  // R3 byte odd
    step(20'h40000, 2'b01, 1'b1, 1'b0, 16'h0000, 16'h0000);  // idle
    step(20'h40021, 2'b10, 1'b0, 1'b1, 16'h5555, 16'h0000);  // R8 first cycle
    step(20'h40021, 2'b10, 1'b0, 1'b1, 16'h5555, 16'h0000);  // R8 held strobe
    step(20'h40020, 2'b10, 1'b1, 1'b0, 16'h0000, 16'h0000);
    step(20'h3FFFE, 2'b10, 1'b1, 1'b1, 16'h0000, 16'h1111);  // R2 below window
    step(20'h50000, 2'b10, 1'b1, 1'b1, 16'h0000, 16'h2222);  // R2 above window
    step(20'h51001, 2'b10, 1'b0, 1'b1, 16'h3333, 16'h0000);  // odd word outside
    step(20'h4FFFF, 2'b00, 1'b0, 1'b1, 16'h7777, 16'h0000);  // R8 code 00 is word
    mixed_run(40, 1);
    // 8-bit port
    do_reset(1'b0);
    step(20'h40100, 2'b01, 1'b0, 1'b1, 16'hA1B2, 16'h0000);  // R6 even byte
    step(20'h40101, 2'b01, 1'b0, 1'b1, 16'hA1B2, 16'h0000);  // R6 odd byte
    step(20'h40103, 2'b10, 1'b0, 1'b1, 16'hC3D4, 16'h0000);  // R4 odd word allowed
    step(20'h40104, 2'b10, 1'b1, 1'b1, 16'h0000, 16'h9A7F);  // R7 read dup
    step(20'h40105, 2'b01, 1'b1, 1'b0, 16'h0000, 16'h1234);
    step(20'h60105, 2'b01, 1'b1, 1'b1, 16'h0000, 16'h4321);
    mixed_run(40, 7);
    // back to 16-bit, strap toggled after release
    do_reset(1'b1);
    mixed_run(30, 3);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule